// File: doc/BRIEF.md
# SD command channel engine

This block drives the command line of a one-bit SD-mode card host. Software sits behind a small bank of 32-bit registers. It loads a six-byte command, one byte per write to a byte port, and the engine then sends that command on the CMD line, most significant bit first. If response capture is enabled, the engine waits for the card's start bit, records the response bit for bit, and flags completion in a pending register. Software then reads the response back through the same byte port, one byte per read.

The line clock is a fixed division of the system clock. The engine changes the CMD line only after a falling edge of that clock, and it samples the card on a rising edge. It stores the response bits exactly as the card sends them, with the start and transmission bits in the top two bits of the first byte. As a result, a short response reads back led by the echoed command index and a long response reads back led by 0x3F. A response window with no start bit ends in a timeout flag rather than a hang.

Top module: `sdc_cmd_engine`

## Requirements
- R1: After reset, every register reads zero (word address 0 enable, 1 pending, 2 start/busy, 3 byte port) and `cmd_oe` is low.
- R2: The enable register (address 0) holds five bits that read back as written: bit 0 command send, bit 1 response capture, bit 2 and bit 3 data-direction enables (stored only), and bit 4 long response (136 bits instead of 48).
- R3: Each write to address 3 stores `reg_wdata[7:0]` at a byte counter that wraps modulo 6. The write that fills byte 5 launches the command when enable bit 0 is set. Byte-port writes made while the engine is busy are dropped and leave the counter unchanged.
- R4: A command is 48 line bits, sent MSB first: a 0, a 1, bits 5:0 of byte 0, bytes 1 to 4 (the argument, high byte first), then byte 5 as written. `cmd_oe` is high for exactly those 48 line-clock periods, and `cmd_out` changes only after a falling line-clock edge.
- R5: Writing 1 to bit 0 of address 2 relaunches the buffered command when enable bit 0 is set and the engine is idle. Reading bit 0 of address 2 gives 1 while the engine is busy. Bit 1 of address 2 (data launch) never starts anything on the CMD line.
- R6: When the last command bit has been sent, the engine releases the line and sets pending bit 0.
- R7: With enable bit 1 set, capture begins at the first 0 sampled on a rising line-clock edge. It stores 48 or 136 bits as 6 or 17 bytes, each byte MSB first, and then sets pending bit 1.
- R8: If no start bit is sampled within 64 rising line-clock edges after the command, the engine sets pending bit 4, leaves pending bit 1 clear, and returns to idle.
- R9: Writing the pending register clears each of bits 0, 1 and 4 that is written as 1 and leaves the bits written as 0 unchanged.
- R10: Reads of address 3 return the captured bytes in order. The read after the last byte returns byte 0 again, because the read pointer wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Word address of the register access |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data is valid the cycle after |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| sd_clk | output | 1 | Card line clock |
| cmd_out | output | 1 | CMD line value driven by the host |
| cmd_oe | output | 1 | Host drives CMD while high |
| cmd_in | input | 1 | CMD line value seen from the card |

## Verification
The in-RTL properties check on every cycle the invariants that involve no scenario. The line value moves only on a falling line-clock tick while driven. The line is released right after the last command bit. The driver enable implies busy. The byte counters stay in range. A write-one-to-clear actually clears. Busy-time byte writes freeze the counter. Other behaviour shows only in the bench's scenarios: the exact bit order on the line, the stored contents of short and long responses, the read-pointer wrap, the timeout outcome, relaunch from the start register, and the gating by the enable bits.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
   typedef enum logic [1:0] {
      REG_ENABLE  = 2'd0,
      REG_PENDING = 2'd1,
      REG_START   = 2'd2,
      REG_CMDBYTE = 2'd3
   } reg_sel_e;

   localparam int EN_CMD_TX  = 0;
   localparam int EN_CMD_RX  = 1;
   localparam int EN_LONG    = 4;
   localparam int EN_W       = 5;

   localparam int PD_CMD_TX  = 0;
   localparam int PD_CMD_RX  = 1;
   localparam int PD_TIMEOUT = 4;

   localparam int ST_CMD_GO  = 0;

   typedef enum logic [1:0] {
      ENG_IDLE,
      ENG_TX,
      ENG_WAIT,
      ENG_RX
   } eng_state_e;
endpackage

// File: rtl/sdc_clk_div.sv
module sdc_clk_div #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic sd_clk,
   output logic rise_tk,
   output logic fall_tk
);
   localparam int HALF = DIV / 2;
   localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

   generate
      if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
         $error("sdc_clk_div: DIV must be even and at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_comb begin
      rise_tk = (cnt == CW'(HALF - 1));
      fall_tk = (cnt == CW'(DIV - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         sd_clk <= 1'b0;
      end else begin
         cnt <= fall_tk ? '0 : cnt + CW'(1);
         if (rise_tk)
            sd_clk <= 1'b1;
         else if (fall_tk)
            sd_clk <= 1'b0;
      end
   end
endmodule

// File: rtl/sdc_cmd_serdes.sv
module sdc_cmd_serdes
   import sdc_pkg::*;
#(
   parameter int CMD_BITS   = 48,
   parameter int SHORT_BITS = 48,
   parameter int LONG_BITS  = 136,
   parameter int TIMEOUT    = 64,
   parameter int IDX_W      = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rise_tk,
   input  logic                fall_tk,
   input  logic                launch,
   input  logic [CMD_BITS-1:0] cmd_vec,
   input  logic                rx_en,
   input  logic                long_rsp,
   input  logic                cmd_in,
   output logic                cmd_out,
   output logic                cmd_oe,
   output logic                busy,
   output logic                tx_done,
   output logic                rx_done,
   output logic                rx_timeout,
   output logic                bit_we,
   output logic [IDX_W-1:0]    bit_idx,
   output logic                bit_val
);
   localparam int TMO_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;

   generate
      if ((CMD_BITS % 8) != 0 || (SHORT_BITS % 8) != 0 || (LONG_BITS % 8) != 0) begin : g_bad_bits
         $error("sdc_cmd_serdes: frame lengths must be whole bytes");
      end
      if (TIMEOUT < 2) begin : g_bad_tmo
         $error("sdc_cmd_serdes: TIMEOUT must be at least 2");
      end
      if ((1 << IDX_W) <= LONG_BITS || (1 << IDX_W) <= CMD_BITS) begin : g_bad_idx
         $error("sdc_cmd_serdes: IDX_W too narrow");
      end
   endgenerate

   eng_state_e          state_q;
   logic [CMD_BITS-1:0] shreg;
   logic [IDX_W-1:0]    cnt;
   logic [IDX_W-1:0]    nbits;
   logic [TMO_W-1:0]    tmo;
   logic                rx_en_q;
   logic                start_seen;
   logic                rx_step;

   always_comb begin
      busy       = (state_q != ENG_IDLE);
      tx_done    = (state_q == ENG_TX) && fall_tk && (cnt == IDX_W'(CMD_BITS));
      start_seen = (state_q == ENG_WAIT) && rise_tk && !cmd_in;
      rx_timeout = (state_q == ENG_WAIT) && rise_tk && cmd_in && (tmo == TMO_W'(TIMEOUT - 1));
      rx_step    = (state_q == ENG_RX) && rise_tk;
      rx_done    = rx_step && (cnt == nbits - IDX_W'(1));
      bit_we     = start_seen || rx_step;
      bit_idx    = start_seen ? '0 : cnt;
      bit_val    = cmd_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         shreg   <= '0;
         cnt     <= '0;
         nbits   <= '0;
         tmo     <= '0;
         rx_en_q <= 1'b0;
         cmd_out <= 1'b1;
         cmd_oe  <= 1'b0;
      end else begin
         unique case (state_q)
            ENG_IDLE: begin
               if (launch) begin
                  shreg   <= cmd_vec;
                  cnt     <= '0;
                  nbits   <= long_rsp ? IDX_W'(LONG_BITS) : IDX_W'(SHORT_BITS);
                  rx_en_q <= rx_en;
                  state_q <= ENG_TX;
               end
            end
            ENG_TX: begin
               if (fall_tk) begin
                  if (cnt == IDX_W'(CMD_BITS)) begin
                     cmd_oe  <= 1'b0;
                     cmd_out <= 1'b1;
                     tmo     <= '0;
                     state_q <= rx_en_q ? ENG_WAIT : ENG_IDLE;
                  end else begin
                     cmd_oe  <= 1'b1;
                     cmd_out <= shreg[CMD_BITS-1];
                     shreg   <= shreg << 1;
                     cnt     <= cnt + IDX_W'(1);
                  end
               end
            end
            ENG_WAIT: begin
               if (start_seen) begin
                  cnt     <= IDX_W'(1);
                  state_q <= ENG_RX;
               end else if (rx_timeout) begin
                  state_q <= ENG_IDLE;
               end else if (rise_tk) begin
                  tmo <= tmo + TMO_W'(1);
               end
            end
            ENG_RX: begin
               if (rx_step) begin
                  if (rx_done)
                     state_q <= ENG_IDLE;
                  else
                     cnt <= cnt + IDX_W'(1);
               end
            end
            default: state_q <= ENG_IDLE;
         endcase
      end
   end

   // R4
   line_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_oe && !$stable(cmd_out)) |-> $past(fall_tk));

   // R6
   line_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> !cmd_oe);

   // R5
   drive_implies_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_oe |-> busy);

   // R8
   timeout_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_timeout |=> !busy);
endmodule

// File: rtl/sdc_resp_buf.sv
module sdc_resp_buf #(
   parameter int MAX_BYTES = 17,
   parameter int IDX_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_we,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic             bit_val,
   input  logic             cap_done,
   input  logic             rd_pulse,
   output logic [7:0]       rd_byte
);
   localparam int PW = $clog2(MAX_BYTES + 1);
   localparam int BW = IDX_W - 3;

   generate
      if ((1 << BW) < MAX_BYTES) begin : g_bad_w
         $error("sdc_resp_buf: IDX_W too narrow for MAX_BYTES");
      end
   endgenerate

   logic [7:0]    rsp_mem [MAX_BYTES];
   logic [PW-1:0] rptr;
   logic [PW-1:0] len;

   generate
      for (genvar i = 0; i < MAX_BYTES; i++) begin : g_byte
         logic [7:0] byte_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               byte_q <= '0;
            else if (bit_we && bit_idx[IDX_W-1:3] == BW'(i))
               byte_q[~bit_idx[2:0]] <= bit_val;
         end
         assign rsp_mem[i] = byte_q;
      end
   endgenerate

   always_comb begin
      rd_byte = '0;
      for (int i = 0; i < MAX_BYTES; i++)
         if (rptr == PW'(i))
            rd_byte = rsp_mem[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rptr <= '0;
         len  <= '0;
      end else begin
         if (cap_done)
            len <= PW'(bit_idx[IDX_W-1:3]) + PW'(1);
         if (bit_we && bit_idx == '0)
            rptr <= '0;
         else if (rd_pulse) begin
            if (len <= PW'(1) || rptr == len - PW'(1))
               rptr <= '0;
            else
               rptr <= rptr + PW'(1);
         end
      end
   end

   // R10
   rptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (len != '0) |-> (rptr < len));
endmodule

// File: rtl/sdc_cmd_engine.sv
module sdc_cmd_engine
   import sdc_pkg::*;
#(
   parameter int DIV         = 4,
   parameter int TIMEOUT     = 64,
   parameter int CMD_BYTES   = 6,
   parameter int SHORT_BYTES = 6,
   parameter int LONG_BYTES  = 17
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  reg_addr,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        sd_clk,
   output logic        cmd_out,
   output logic        cmd_oe,
   input  logic        cmd_in
);
   localparam int CMD_BITS = 8 * CMD_BYTES;
   localparam int IDX_W    = $clog2(8 * LONG_BYTES + 1);
   localparam int WP_W     = $clog2(CMD_BYTES);
   localparam int LAST     = CMD_BYTES - 1;

   generate
      if (LONG_BYTES < SHORT_BYTES || LONG_BYTES < CMD_BYTES || CMD_BYTES < 2) begin : g_bad_len
         $error("sdc_cmd_engine: inconsistent frame lengths");
      end
   endgenerate

   logic                rise_tk, fall_tk;
   logic [EN_W-1:0]     en_q;
   logic                pend_tx, pend_rx, pend_tmo;
   logic [7:0]          cmd_buf [CMD_BYTES];
   logic [WP_W-1:0]     wptr;
   logic [CMD_BITS-1:0] cmd_vec;
   logic                busy, tx_done, rx_done, rx_timeout;
   logic                bit_we, bit_val;
   logic [IDX_W-1:0]    bit_idx;
   logic [7:0]          rd_byte;
   logic                cmd_wr, last_wr, go_wr, launch, rd_pulse, pend_wr;
   logic                unused_wbits;

   assign unused_wbits = ^reg_wdata[31:8];

   always_comb begin
      pend_wr  = reg_wr && (reg_addr == REG_PENDING);
      cmd_wr   = reg_wr && (reg_addr == REG_CMDBYTE) && !busy;
      last_wr  = cmd_wr && (wptr == WP_W'(LAST));
      go_wr    = reg_wr && (reg_addr == REG_START) && reg_wdata[ST_CMD_GO] && !busy;
      launch   = (last_wr || go_wr) && en_q[EN_CMD_TX];
      rd_pulse = reg_rd && (reg_addr == REG_CMDBYTE);
   end

   generate
      for (genvar i = 0; i < CMD_BYTES; i++) begin : g_vec
         if (i == 0) begin : g_head
            assign cmd_vec[CMD_BITS-1 -: 8] = {2'b01, cmd_buf[0][5:0]};
         end else if (i == LAST) begin : g_tail
            assign cmd_vec[7:0] = last_wr ? reg_wdata[7:0] : cmd_buf[LAST];
         end else begin : g_mid
            assign cmd_vec[8*(CMD_BYTES-i)-1 -: 8] = cmd_buf[i];
         end
      end
   endgenerate

   sdc_clk_div #(.DIV(DIV)) i_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .sd_clk  (sd_clk),
      .rise_tk (rise_tk),
      .fall_tk (fall_tk)
   );

   sdc_cmd_serdes #(
      .CMD_BITS   (CMD_BITS),
      .SHORT_BITS (8 * SHORT_BYTES),
      .LONG_BITS  (8 * LONG_BYTES),
      .TIMEOUT    (TIMEOUT),
      .IDX_W      (IDX_W)
   ) i_serdes (
      .clk        (clk),
      .rst_n      (rst_n),
      .rise_tk    (rise_tk),
      .fall_tk    (fall_tk),
      .launch     (launch),
      .cmd_vec    (cmd_vec),
      .rx_en      (en_q[EN_CMD_RX]),
      .long_rsp   (en_q[EN_LONG]),
      .cmd_in     (cmd_in),
      .cmd_out    (cmd_out),
      .cmd_oe     (cmd_oe),
      .busy       (busy),
      .tx_done    (tx_done),
      .rx_done    (rx_done),
      .rx_timeout (rx_timeout),
      .bit_we     (bit_we),
      .bit_idx    (bit_idx),
      .bit_val    (bit_val)
   );

   sdc_resp_buf #(
      .MAX_BYTES (LONG_BYTES),
      .IDX_W     (IDX_W)
   ) i_rbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_we   (bit_we),
      .bit_idx  (bit_idx),
      .bit_val  (bit_val),
      .cap_done (rx_done),
      .rd_pulse (rd_pulse),
      .rd_byte  (rd_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q     <= '0;
         pend_tx  <= 1'b0;
         pend_rx  <= 1'b0;
         pend_tmo <= 1'b0;
         wptr     <= '0;
         for (int i = 0; i < CMD_BYTES; i++)
            cmd_buf[i] <= '0;
      end else begin
         if (reg_wr && reg_addr == REG_ENABLE)
            en_q <= reg_wdata[EN_W-1:0];
         pend_tx  <= (pend_tx  && !(pend_wr && reg_wdata[PD_CMD_TX]))  || tx_done;
         pend_rx  <= (pend_rx  && !(pend_wr && reg_wdata[PD_CMD_RX]))  || rx_done;
         pend_tmo <= (pend_tmo && !(pend_wr && reg_wdata[PD_TIMEOUT])) || rx_timeout;
         if (cmd_wr) begin
            cmd_buf[wptr] <= reg_wdata[7:0];
            wptr <= last_wr ? '0 : wptr + WP_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata <= '0;
      end else if (reg_rd) begin
         unique case (reg_addr)
            REG_ENABLE:  reg_rdata <= 32'(en_q);
            REG_PENDING: reg_rdata <= 32'({pend_tmo, 2'b00, pend_rx, pend_tx});
            REG_START:   reg_rdata <= 32'(busy);
            default:     reg_rdata <= 32'(rd_byte);
         endcase
      end
   end

   // R3
   wptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wptr <= WP_W'(LAST));

   // R3
   busy_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == REG_CMDBYTE && busy) |=> $stable(wptr));

   // R9
   w1c_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_wr && reg_wdata[PD_CMD_RX] && !rx_done) |=> !pend_rx);
endmodule

// File: tb/test_sdc_cmd_engine.sv
module test_sdc_cmd_engine;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  reg_addr;
   logic        reg_wr, reg_rd;
   logic [31:0] reg_wdata, reg_rdata;
   logic        sd_clk, cmd_out, cmd_oe, cmd_in;

   always #5 clk = ~clk;

   sdc_cmd_engine i_sdc_cmd_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .sd_clk    (sd_clk),
      .cmd_out   (cmd_out),
      .cmd_oe    (cmd_oe),
      .cmd_in    (cmd_in)
   );

   int         n_chk = 0;
   int         n_fail = 0;
   bit         done = 1'b0;
   logic [7:0] exp_q [$];
   logic [7:0] rsp_pat [17];
   logic [7:0] mon_sh;
   logic [7:0] mon_exp;
   int         mon_n = 0;
   int         tx_bits = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // monitor: rebuild bytes seen on the line and pop expected ones (R4)
   always @(posedge sd_clk) begin
      if (cmd_oe) begin
         mon_sh = {mon_sh[6:0], cmd_out};
         mon_n++;
         tx_bits++;
         if (mon_n == 8) begin
            mon_n = 0;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4 unexpected line byte", 32'(mon_sh), 32'h0);
            end else begin
               mon_exp = exp_q.pop_front();
               chk(mon_sh == mon_exp, "R4 line byte", 32'(mon_sh), 32'(mon_exp));
            end
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   // driver: write six bytes, pushing what the line must carry
   task automatic send_cmd(input logic [7:0] b0, input logic [31:0] arg, input logic [7:0] crc, input bit expect_tx);
      if (expect_tx) begin
         exp_q.push_back({2'b01, b0[5:0]});
         exp_q.push_back(arg[31:24]);
         exp_q.push_back(arg[23:16]);
         exp_q.push_back(arg[15:8]);
         exp_q.push_back(arg[7:0]);
         exp_q.push_back(crc);
      end
      wr(2'd3, 32'hABCD_EF00 | 32'(b0));
      wr(2'd3, 32'(arg[31:24]));
      wr(2'd3, 32'(arg[23:16]));
      wr(2'd3, 32'(arg[15:8]));
      wr(2'd3, 32'(arg[7:0]));
      wr(2'd3, 32'(crc));
   endtask

   task automatic card_resp(input int n);
      @(negedge cmd_oe);
      repeat (2) @(negedge sd_clk);
      for (int i = 0; i < n; i++)
         for (int b = 7; b >= 0; b--) begin
            cmd_in = rsp_pat[i][b];
            @(negedge sd_clk);
         end
      cmd_in = 1'b1;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 3000; i++) begin
         rd(2'd2, v);
         if (!v[0]) break;
      end
   endtask

   task automatic read_resp(input int n, input string req);
      logic [31:0] v;
      for (int i = 0; i < n; i++) begin
         rd(2'd3, v);
         chk(v == 32'(rsp_pat[i]), req, v, 32'(rsp_pat[i]));
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      rst_n = 1'b0; cmd_in = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0;
      reg_addr = '0; reg_wdata = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk(cmd_oe == 1'b0, "R1 cmd_oe", 32'(cmd_oe), 32'h0);
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         chk(v == 32'h0, "R1 register reset", v, 32'h0);
      end

      // R2 enable readback
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, v);
      chk(v == 32'h1F, "R2 enable readback", v, 32'h1F);
      wr(2'd0, 32'h03);
      rd(2'd0, v);
      chk(v == 32'h03, "R2 enable readback", v, 32'h03);

      // short command with short response
      rsp_pat[0] = 8'h11; rsp_pat[1] = 8'h00; rsp_pat[2] = 8'h00;
      rsp_pat[3] = 8'h09; rsp_pat[4] = 8'h00; rsp_pat[5] = 8'h1B;
      tx_bits = 0;
      send_cmd(8'hD1, 32'h1234_5678, 8'h55, 1'b1);
      rd(2'd2, v);
      chk(v[0] == 1'b1, "R5 busy during send", v, 32'h1);
      wr(2'd3, 32'hAA);  // R3 dropped while busy
      card_resp(6);
      wait_idle();
      chk(tx_bits == 48, "R4 bit count", 32'(tx_bits), 32'd48);
      rd(2'd1, v);
      chk(v == 32'h03, "R6 R7 pending after short", v, 32'h03);
      read_resp(6, "R7 short response byte");
      rd(2'd3, v);
      chk(v == 32'(rsp_pat[0]), "R10 pointer wrap", v, 32'(rsp_pat[0]));

      // R9 write-one-to-clear
      wr(2'd1, 32'h01);
      rd(2'd1, v);
      chk(v == 32'h02, "R9 clear tx only", v, 32'h02);
      wr(2'd1, 32'h00);
      rd(2'd1, v);
      chk(v == 32'h02, "R9 zero write keeps", v, 32'h02);
      wr(2'd1, 32'h02);
      rd(2'd1, v);
      chk(v == 32'h00, "R9 clear rx", v, 32'h00);

      // long response
      wr(2'd0, 32'h13);
      for (int i = 0; i < 17; i++) rsp_pat[i] = (i == 0) ? 8'h3F : 8'(i * 13 + 5);
      tx_bits = 0;
      send_cmd(8'h02, 32'h0000_0000, 8'h4D, 1'b1);
      card_resp(17);
      wait_idle();
      chk(tx_bits == 48, "R3 aligned after dropped write", 32'(tx_bits), 32'd48);
      rd(2'd1, v);
      chk(v == 32'h03, "R7 pending after long", v, 32'h03);
      read_resp(17, "R7 long response byte");
      rd(2'd3, v);
      chk(v == 32'h3F, "R10 long wrap", v, 32'h3F);
      wr(2'd1, 32'h13);

      // R8 timeout, no card answer
      wr(2'd0, 32'h03);
      send_cmd(8'h08, 32'h0000_01AA, 8'h87, 1'b1);
      wait_idle();
      rd(2'd1, v);
      chk(v == 32'h11, "R8 timeout pending", v, 32'h11);
      wr(2'd1, 32'h13);

      // R3 send disabled; R5 data launch and gated start do nothing
      wr(2'd0, 32'h0E);
      tx_bits = 0;
      send_cmd(8'h37, 32'hCAFE_0001, 8'h65, 1'b0);
      wr(2'd2, 32'h02);
      wr(2'd2, 32'h01);
      repeat (100) @(negedge clk);
      chk(tx_bits == 0, "R3 R5 no send when disabled", 32'(tx_bits), 32'd0);
      rd(2'd2, v);
      chk(v == 32'h0, "R5 idle", v, 32'h0);

      // R5 relaunch buffered command, capture off
      wr(2'd0, 32'h01);
      exp_q.push_back(8'h77); exp_q.push_back(8'hCA); exp_q.push_back(8'hFE);
      exp_q.push_back(8'h00); exp_q.push_back(8'h01); exp_q.push_back(8'h65);
      wr(2'd2, 32'h01);
      wait_idle();
      chk(tx_bits == 48, "R5 relaunch bit count", 32'(tx_bits), 32'd48);
      rd(2'd1, v);
      chk(v == 32'h01, "R6 pending without capture", v, 32'h01);
      chk(exp_q.size() == 0, "R4 all bytes seen", 32'(exp_q.size()), 32'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule